// File: doc/BRIEF.md
# Byte-Banked Interrupt Aggregator

The aggregator collects a set of interrupt request lines, grouped into byte-wide banks, and folds them into one interrupt line toward a processor. Every bank has a status byte and an enable (mask) byte. Both are reached over a small synchronous register port that uses a select strobe, a write flag, an address and a byte of write data. Reads return their data on the cycle after the strobe. With the default parameters there are 24 sources in three banks.

All sources but one are edge-sensitive. A rising edge on an enabled source sets a sticky status bit. Reading that bank's status byte clears the sticky bit again, so no acknowledge register is needed. Edge capture is gated by the enable bit: an edge that arrives while its source is disabled is never recorded. One source, chosen by a parameter, is level-sensitive. Its status bit shows the input level, and reading the status byte does not clear it. The output line is the registered OR of every status bit whose enable bit is set. The processor is meant to detect this line on its rising edge.

Top module: `irq_bank_aggregator`

## Requirements
- R1: After reset every mask byte, every status byte, the read data and `irq_out` are all 0.
- R2: Address 2*b selects the status byte of bank b and address 2*b+1 selects its mask byte (bank b holds sources 8*b to 8*b+7, and bit i of a byte is source 8*b+i). Read data appears on `bus_rdata` the cycle after the strobe and holds until the next read. A read of an address at or above 2*N_BANKS returns 0.
- R3: A write to a mask address stores the byte, and the byte reads back unchanged. A write to a status address changes nothing.
- R4: A 0-to-1 transition on an edge source whose mask bit is 1 sets its status bit. The bit stays set after the input falls, until the bank's status byte is read.
- R5: A rising edge on an edge source whose mask bit is 0 is lost. It does not appear in status or on `irq_out` after the source is later enabled.
- R6: A read of a bank's status byte returns the value from before the clear, and then clears that bank's edge bits. The status bytes of other banks are untouched.
- R7: If a new rising edge on an enabled source arrives in the same cycle as a status read of its bank, the read returns the old value and the status bit ends up set.
- R8: The level source (default source 5, bank 0 bit 5) has a status bit equal to its input level, delayed by one cycle. A status read does not clear it, whatever its mask.
- R9: `irq_out` is 1 exactly one cycle after any bank has a status bit set whose mask bit is also 1, and 0 otherwise.
- R10: Clearing a mask bit forces its source out of `irq_out` but keeps its latched status bit. Setting the mask bit again brings the source back onto `irq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_BANKS*BANK_W (24) | Interrupt request lines |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read for the strobed access |
| bus_addr | input | clog2(2*N_BANKS) (3) | Register address |
| bus_wdata | input | BANK_W (8) | Write data |
| bus_rdata | output | BANK_W (8) | Registered read data |
| irq_out | output | 1 | Combined interrupt line |

## Verification
The bench aims at five corner cases.
- An edge raised while its source is masked and then unmasked: a design that latched regardless of mask would show a stale event.
- A rising edge landing on the very cycle of a status read: a design where the clear wins would drop the event.
- Reading one bank's status: a decoder that clears too broadly would wipe another bank's pending bits.
- The level source read twice: a design that treated it as an edge would clear it on the first read.
- Disabling and re-enabling a latched source: the output must follow the mask while the status bit persists.

A long random run with a fixed seed then compares every read and the output line, cycle by cycle, against a model in the bench.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // Low address bit picks the register kind inside a bank.
  typedef enum logic {
    REG_STATUS = 1'b0,
    REG_MASK   = 1'b1
  } reg_kind_e;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_agg_pkg::*;
#(
  parameter int N_BANKS = 3,
  parameter int ADDR_W  = 3,
  localparam int BIDX_W = (ADDR_W > 1) ? ADDR_W - 1 : 1
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [N_BANKS-1:0] stat_rd,
  output logic [N_BANKS-1:0] mask_we,
  output logic              rd_hit,
  output logic              rd_is_mask,
  output logic [BIDX_W-1:0] rd_bank
);
  logic      in_range;
  reg_kind_e kind;

  always_comb begin
    in_range   = int'(bus_addr) < 2 * N_BANKS;
    kind       = reg_kind_e'(bus_addr[0]);
    rd_bank    = BIDX_W'(bus_addr >> 1);
    rd_is_mask = (kind == REG_MASK);
    rd_hit     = bus_sel && !bus_wr && in_range;
    stat_rd    = '0;
    mask_we    = '0;
    if (bus_sel && in_range) begin
      if (bus_wr && kind == REG_MASK)
        mask_we[rd_bank] = 1'b1;
      else if (!bus_wr && kind == REG_STATUS)
        stat_rd[rd_bank] = 1'b1;
    end
  end

  // R2: at most one bank is touched per strobe
  always_comb begin
    assert ($onehot0(stat_rd | mask_we));
  end
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int             BANK_W   = 8,
  parameter logic [BANK_W-1:0] LVL_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] src,
  input  logic              clr_rd,
  input  logic              mask_we,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] status_o,
  output logic [BANK_W-1:0] mask_o,
  output logic [BANK_W-1:0] pend_o
);
  localparam logic [BANK_W-1:0] EDGE_MASK = ~LVL_MASK;

  logic [BANK_W-1:0] src_q;
  logic [BANK_W-1:0] stat_q;
  logic [BANK_W-1:0] mask_q;
  logic [BANK_W-1:0] rise;

  // capture gated by the enable bit held before this edge
  assign rise = src & ~src_q & mask_q & EDGE_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      src_q  <= src;
      if (mask_we) mask_q <= wdata;
      stat_q <= (clr_rd ? '0 : stat_q) | rise;
    end
  end

  assign status_o = stat_q | (src_q & LVL_MASK);
  assign mask_o   = mask_q;
  assign pend_o   = status_o & mask_q;

  // R5: a bit may only become set if its enable was on the cycle before
  p_masked_edge_lost_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(mask_q)) == '0));

  // R4: latched edge bits stay set unless a status read happened
  p_edge_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    !clr_rd |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R6: after a read only freshly rising inputs may remain latched
  p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
    clr_rd |=> ((stat_q & ~($past(src) & ~$past(src_q))) == '0));

  // R8: level bit mirrors the input one cycle later
  p_level_tracks_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_o & LVL_MASK) == ($past(src) & LVL_MASK)));
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int N_SRC = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] pend,
  output logic             irq_out
);
  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |pend;
  end
endmodule

// File: rtl/irq_bank_aggregator.sv
module irq_bank_aggregator #(
  parameter int N_BANKS   = 3,
  parameter int BANK_W    = 8,
  parameter int LEVEL_SRC = 5,
  localparam int N_SRC  = N_BANKS * BANK_W,
  localparam int ADDR_W = $clog2(2 * N_BANKS),
  localparam int BIDX_W = (ADDR_W > 1) ? ADDR_W - 1 : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  irq_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BANK_W-1:0] bus_wdata,
  output logic [BANK_W-1:0] bus_rdata,
  output logic              irq_out
);
  logic [N_BANKS-1:0] stat_rd;
  logic [N_BANKS-1:0] mask_we;
  logic               rd_hit;
  logic               rd_is_mask;
  logic [BIDX_W-1:0]  rd_bank;
  logic [BANK_W-1:0]  stat_a [N_BANKS];
  logic [BANK_W-1:0]  mask_a [N_BANKS];
  logic [N_SRC-1:0]   pend_flat;
  logic [N_SRC-1:0]   mask_flat;

  irq_reg_decode #(.N_BANKS(N_BANKS), .ADDR_W(ADDR_W)) u_dec (
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .stat_rd    (stat_rd),
    .mask_we    (mask_we),
    .rd_hit     (rd_hit),
    .rd_is_mask (rd_is_mask),
    .rd_bank    (rd_bank)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    localparam logic [BANK_W-1:0] LM =
      (LEVEL_SRC / BANK_W == b) ? (BANK_W'(1) << (LEVEL_SRC % BANK_W)) : '0;
    logic [BANK_W-1:0] pend_b;
    irq_bank #(.BANK_W(BANK_W), .LVL_MASK(LM)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .src      (irq_in[b*BANK_W +: BANK_W]),
      .clr_rd   (stat_rd[b]),
      .mask_we  (mask_we[b]),
      .wdata    (bus_wdata),
      .status_o (stat_a[b]),
      .mask_o   (mask_a[b]),
      .pend_o   (pend_b)
    );
    assign pend_flat[b*BANK_W +: BANK_W] = pend_b;
    assign mask_flat[b*BANK_W +: BANK_W] = mask_a[b];
  end

  irq_combine #(.N_SRC(N_SRC)) u_comb (
    .clk     (clk),
    .rst     (rst),
    .pend    (pend_flat),
    .irq_out (irq_out)
  );

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_sel && !bus_wr)
      bus_rdata <= !rd_hit ? '0 : (rd_is_mask ? mask_a[rd_bank] : stat_a[rd_bank]);
  end

  // R10: with every enable off the line drops on the next cycle
  p_quiet_when_masked_r10: assert property (@(posedge clk) disable iff (rst)
    (mask_flat == '0) |=> !irq_out);
endmodule

// File: tb/irq_bank_aggregator_bench.sv
`timescale 1ns/1ps
module irq_bank_aggregator_bench;
  localparam int NB = 3;
  localparam int W  = 8;
  localparam int NS = NB * W;
  localparam logic [NS-1:0] LVLM = NS'(1) << 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] irq_in = '0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic          irq_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_bank_aggregator u_irq_bank_aggregator (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // Bench model built from the requirements
  logic [NS-1:0] m_prev, m_stat, m_mask;
  logic [W-1:0]  m_rd;
  logic          m_out;

  always @(posedge clk) begin : model
    logic [NS-1:0] full, pend, rise, nstat;
    int b;
    if (rst) begin
      m_prev = '0; m_stat = '0; m_mask = '0; m_rd = '0; m_out = 1'b0;
    end else begin
      full  = m_stat | (m_prev & LVLM);
      pend  = full & m_mask;
      rise  = irq_in & ~m_prev & m_mask & ~LVLM;
      nstat = m_stat;
      b = int'(bus_addr) / 2;
      if (bus_sel && !bus_wr) begin
        if (bus_addr < 3'd6) begin
          m_rd = bus_addr[0] ? m_mask[b*W +: W] : full[b*W +: W];
          if (!bus_addr[0]) nstat[b*W +: W] = '0;
        end else m_rd = '0;
      end
      if (bus_sel && bus_wr && bus_addr < 3'd6 && bus_addr[0])
        m_mask[b*W +: W] = bus_wdata;
      m_stat = nstat | rise;
      m_out  = |pend;
      m_prev = irq_in;
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_in(input int idx, input logic v);
    @(negedge clk);
    irq_in[idx] = v;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] d;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state, R2 unused address
    chk("R1 irq_out", {7'b0, irq_out}, 8'h00);
    chk("R1 rdata", bus_rdata, 8'h00);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d); chk("R1 reg", d, 8'h00);
    end
    wr(3'd7, 8'hFF); rd(3'd7, d); chk("R2 unmapped", d, 8'h00);

    // R3 mask write/readback, status write ignored
    wr(3'd3, 8'hA5); rd(3'd3, d); chk("R3 mask1", d, 8'hA5);
    wr(3'd2, 8'hFF); rd(3'd2, d); chk("R3 status write", d, 8'h00);

    // R5 edge while masked is lost
    set_in(2, 1'b1); idle(2); set_in(2, 1'b0); idle(2);
    wr(3'd1, 8'h04); idle(2);
    chk("R5 irq_out", {7'b0, irq_out}, 8'h00);
    rd(3'd0, d); chk("R5 status0", d, 8'h00);

    // R4 capture, R9 output, R6 clear on read
    set_in(2, 1'b1); idle(2);
    chk("R9 irq_out high", {7'b0, irq_out}, 8'h01);
    set_in(2, 1'b0); idle(2);
    rd(3'd0, d); chk("R4 sticky", d, 8'h04);
    idle(2); chk("R9 irq_out low", {7'b0, irq_out}, 8'h00);
    rd(3'd0, d); chk("R6 cleared", d, 8'h00);

    // R6 bank isolation
    wr(3'd5, 8'hFF);
    set_in(8, 1'b1); set_in(17, 1'b1); idle(2);
    rd(3'd4, d); chk("R6 status2", d, 8'h02);
    rd(3'd2, d); chk("R6 status1 kept", d, 8'h01);
    rd(3'd2, d); chk("R6 status1 cleared", d, 8'h00);
    rd(3'd4, d); chk("R6 status2 cleared", d, 8'h00);

    // R7 edge in the same cycle as a status read
    @(negedge clk);
    irq_in[16] = 1'b1; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'd4;
    @(negedge clk);
    bus_sel = 1'b0; d = bus_rdata;
    chk("R7 old value", d, 8'h00);
    rd(3'd4, d); chk("R7 edge survives", d, 8'h01);

    // R8 level source
    set_in(5, 1'b1); idle(2);
    rd(3'd0, d); chk("R8 level", d, 8'h20);
    rd(3'd0, d); chk("R8 not cleared", d, 8'h20);
    chk("R8 masked level", {7'b0, irq_out}, 8'h00);
    wr(3'd1, 8'h24); idle(2);
    chk("R9 level pending", {7'b0, irq_out}, 8'h01);
    set_in(5, 1'b0); idle(2);
    rd(3'd0, d); chk("R8 level low", d, 8'h00);
    chk("R8 irq_out low", {7'b0, irq_out}, 8'h00);

    // R10 mask removal keeps latched status
    set_in(20, 1'b1); idle(2);
    chk("R4 bank2 edge", {7'b0, irq_out}, 8'h01);
    wr(3'd5, 8'h00); idle(2);
    chk("R10 masked off", {7'b0, irq_out}, 8'h00);
    wr(3'd5, 8'hFF); idle(2);
    chk("R10 re-enabled", {7'b0, irq_out}, 8'h01);
    rd(3'd4, d); chk("R10 status kept", d, 8'h10);
    idle(2); chk("R9 cleared out", {7'b0, irq_out}, 8'h00);

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      chk("R2 random rdata", bus_rdata, m_rd);
      chk("R9 random irq_out", {7'b0, irq_out}, {7'b0, m_out});
      if ($urandom % 4 == 0) irq_in[$urandom % NS] ^= 1'b1;
      bus_sel   = ($urandom % 2) == 0;
      bus_wr    = ($urandom % 3) == 0;
      bus_addr  = 3'($urandom % 8);
      bus_wdata = 8'($urandom);
    end
    @(negedge clk);
    bus_sel = 1'b0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule